// File: doc/BRIEF.md
# Shader Uniform and Varying Stream Read Port

This block answers the register-space reads that a shader instruction makes to pull per-shader data. A read of the uniform address returns the next 32-bit word of a uniform list. The list is prefetched from memory through a simple request/response port into a small queue. Writing a new base pointer restarts the list from that address. A read of the varying address in the B file returns the next partially interpolated value V. The interpolator feeds these values, together with their C coefficients, into a second queue. Each such read also drives the coefficient onto the accumulator-5 write port, so the following instruction can complete `V*W + C`.

The block also holds the per-pixel W value as a pair of registers. The current pixel's W is read at A-file address 15. The next pixel's W is written into the slot seen at address 14. At the start of each pixel the address LSB is flipped, so that value becomes the new address 15. If an instruction reads a stream whose queue is empty, the block stalls it instead of returning stale data. An error pulse reports two things: stream reads in the program-end instruction or its two delay slots, and varyings left unread at program end.

Top module: `shd_stream_port`

## Requirements
- R1: An issued instruction that reads address 32 on port A or port B (`rd_en_*_i` high) pops one uniform. Uniforms come out in list order, from byte addresses base, base+4, base+8 and so on. When both ports read 32 in the same instruction, both return the same word and only one pop occurs.
- R2: An issued instruction with `ubase_we_i` high still returns the old queue head to its own reads. It then discards every buffered and in-flight uniform, and the next uniform read returns the word at `ubase_i`.
- R3: An issued instruction that reads address 35 on port B returns the next varying V in push order and advances by one. Address 35 on port A returns zero and pops nothing.
- R4: In the cycle a varying is popped, `acc5_we_o` is high and `acc5_data_o` carries that varying's C. In every other cycle `acc5_we_o` is low.
- R5: Port A address 15 returns the current W, and address 14 returns the next W. `w_we_i` writes the next W without changing the value at address 15. `pix_start_i` swaps the two, so the value last written appears at address 15.
- R6: When an instruction reads a stream whose queue is empty, `stall_o` is high, nothing is popped, and `acc5_we_o` stays low. The instruction completes when data arrives.
- R7: `err_o` pulses for one cycle, in the cycle after issue, when a uniform or varying read issues in the program-end instruction or in either of the two instructions issued after it.
- R8: `err_o` pulses in the cycle after a program-end instruction issues if, counting that instruction's own reads, fewer than `cfg_vary_cnt_i` varyings have been read since the last `pix_start_i`.
- R9: No memory request is made after reset until a base pointer has been written. Buffered plus outstanding uniform words never exceed `UQ_DEPTH`. A request held without acceptance keeps its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_vary_cnt_i | input | CNTW | Varyings each pixel must read |
| issue_i | input | 1 | An instruction is presented |
| prog_end_i | input | 1 | Presented instruction is program end |
| rd_en_a_i | input | 1 | Port A reads `rd_addr_a_i` |
| rd_addr_a_i | input | RAW | Port A register address |
| rd_en_b_i | input | 1 | Port B reads `rd_addr_b_i` |
| rd_addr_b_i | input | RAW | Port B register address |
| ubase_we_i | input | 1 | Instruction writes the uniform base pointer |
| ubase_i | input | AW | New base pointer (lane 0 value) |
| pix_start_i | input | 1 | New pixel: flip W, reload varying count |
| w_we_i | input | 1 | Write next-pixel W |
| w_data_i | input | DW | Next-pixel W value |
| vary_push_i | input | 1 | Interpolator pushes one varying |
| vary_v_i | input | DW | Partial value V |
| vary_c_i | input | DW | Coefficient C |
| vary_ready_o | output | 1 | Varying queue has room |
| mreq_valid_o | output | 1 | Uniform fetch request valid |
| mreq_ready_i | input | 1 | Memory accepts request |
| mreq_addr_o | output | AW | Uniform fetch byte address |
| mrsp_valid_i | input | 1 | Memory returns a word, in request order |
| mrsp_data_i | input | DW | Returned word |
| stall_o | output | 1 | Presented instruction must wait |
| rd_data_a_o | output | DW | Port A read data |
| rd_data_b_o | output | DW | Port B read data |
| acc5_we_o | output | 1 | Accumulator 5 write enable |
| acc5_data_o | output | DW | Accumulator 5 write data (C) |
| err_o | output | 1 | Program-end rule violated |

## Verification
The bench rewinds the uniform pointer at random while memory ready and response timing are also random. A design that let an in-flight response from the old list reach the queue would return a stale word right after the rewind. It issues reads against empty queues. A design without the stall would hand back old data or fire the accumulator-5 write, which would shift every later varying by one. It reads A15 after a next-W write but before the pixel flip; a design that wrote the live slot would change W mid-pixel. It places stream reads in each delay slot and leaves a varying unread at program end; a design that counted delay slots in cycles instead of issued instructions, or that checked the count before the final instruction's own read, would report the wrong pulse.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [5:0] ADDR_UNIF  = 6'd32;
  localparam logic [5:0] ADDR_VARY  = 6'd35;
  localparam logic [5:0] ADDR_W_CUR = 6'd15;
  localparam logic [5:0] ADDR_W_NXT = 6'd14;
  localparam int unsigned TAIL_SLOTS = 2;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    rp_q, wp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != CW'(DEPTH)) || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/ssp_unif_fetch.sv
module ssp_unif_fetch #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int STEP = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rewind_i,
  input  logic [AW-1:0] base_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic [DW-1:0] data_o,
  output logic          mreq_valid_o,
  input  logic          mreq_ready_i,
  output logic [AW-1:0] mreq_addr_o,
  input  logic          mrsp_valid_i,
  input  logic [DW-1:0] mrsp_data_i
);
  logic          armed_q;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] infl_q, infl_n, drop_q, cnt;
  logic          credit, acc, keep;

  // buffered + outstanding words bounded by queue depth
  assign credit       = ({1'b0, cnt} + {1'b0, infl_q}) < (CW+1)'(DEPTH);
  assign mreq_valid_o = armed_q && !rewind_i && credit;
  assign mreq_addr_o  = ptr_q;
  assign acc          = mreq_valid_o && mreq_ready_i;
  assign keep         = mrsp_valid_i && (drop_q == '0) && !rewind_i;
  assign infl_n       = infl_q + CW'(acc) - CW'(mrsp_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ptr_q   <= '0;
      infl_q  <= '0;
      drop_q  <= '0;
    end else begin
      infl_q <= infl_n;
      if (rewind_i) begin
        armed_q <= 1'b1;
        ptr_q   <= base_i;
        drop_q  <= infl_n;  // everything still in flight belongs to the old list
      end else begin
        if (acc) ptr_q <= ptr_q + AW'(STEP);
        if (mrsp_valid_i && (drop_q != '0)) drop_q <= drop_q - 1'b1;
      end
    end
  end

  ssp_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rewind_i),
    .push_i  (keep),
    .wdata_i (mrsp_data_i),
    .pop_i   (pop_i),
    .rdata_o (data_o),
    .empty_o (empty_o),
    .count_o (cnt)
  );
endmodule

// File: rtl/ssp_wpair.sv
module ssp_wpair #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flip_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cur_o,
  output logic [DW-1:0] nxt_o
);
  logic [DW-1:0] ent_q [2];
  logic          sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q[0] <= '0;
      ent_q[1] <= '0;
      sel_q    <= 1'b0;
    end else begin
      if (wr_i)   ent_q[sel_q] <= wdata_i;
      if (flip_i) sel_q <= ~sel_q;
    end
  end

  // address LSB xor sel picks the physical entry
  assign cur_o = ent_q[~sel_q];
  assign nxt_o = ent_q[sel_q];
endmodule

// File: rtl/shd_stream_port.sv
module shd_stream_port
  import ssp_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int RAW      = 6,
  parameter int CNTW     = 6,
  parameter int UQ_DEPTH = 4,
  parameter int VQ_DEPTH = 4,
  localparam int VCW     = $clog2(VQ_DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CNTW-1:0] cfg_vary_cnt_i,
  input  logic            issue_i,
  input  logic            prog_end_i,
  input  logic            rd_en_a_i,
  input  logic [RAW-1:0]  rd_addr_a_i,
  input  logic            rd_en_b_i,
  input  logic [RAW-1:0]  rd_addr_b_i,
  input  logic            ubase_we_i,
  input  logic [AW-1:0]   ubase_i,
  input  logic            pix_start_i,
  input  logic            w_we_i,
  input  logic [DW-1:0]   w_data_i,
  input  logic            vary_push_i,
  input  logic [DW-1:0]   vary_v_i,
  input  logic [DW-1:0]   vary_c_i,
  output logic            vary_ready_o,
  output logic            mreq_valid_o,
  input  logic            mreq_ready_i,
  output logic [AW-1:0]   mreq_addr_o,
  input  logic            mrsp_valid_i,
  input  logic [DW-1:0]   mrsp_data_i,
  output logic            stall_o,
  output logic [DW-1:0]   rd_data_a_o,
  output logic [DW-1:0]   rd_data_b_o,
  output logic            acc5_we_o,
  output logic [DW-1:0]   acc5_data_o,
  output logic            err_o
);
  logic            fire, u_req, v_req, u_pop, v_pop, s_rd;
  logic            u_empty, v_empty;
  logic [DW-1:0]   u_data, w_cur, w_nxt;
  logic [2*DW-1:0] v_head;
  logic [VCW-1:0]  v_cnt;
  logic [CNTW-1:0] left_q, left_after;
  logic [1:0]      tail_q;
  logic            err_q, err_d;

  assign u_req = (rd_en_a_i && rd_addr_a_i == RAW'(ADDR_UNIF)) ||
                 (rd_en_b_i && rd_addr_b_i == RAW'(ADDR_UNIF));
  assign v_req = rd_en_b_i && rd_addr_b_i == RAW'(ADDR_VARY);

  assign stall_o = issue_i && ((u_req && u_empty) || (v_req && v_empty));
  assign fire    = issue_i && !stall_o;
  assign u_pop   = fire && u_req;
  assign v_pop   = fire && v_req;
  assign s_rd    = u_req || v_req;

  ssp_unif_fetch #(.DW(DW), .AW(AW), .DEPTH(UQ_DEPTH)) u_unif (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rewind_i     (fire && ubase_we_i),
    .base_i       (ubase_i),
    .pop_i        (u_pop),
    .empty_o      (u_empty),
    .data_o       (u_data),
    .mreq_valid_o (mreq_valid_o),
    .mreq_ready_i (mreq_ready_i),
    .mreq_addr_o  (mreq_addr_o),
    .mrsp_valid_i (mrsp_valid_i),
    .mrsp_data_i  (mrsp_data_i)
  );

  ssp_fifo #(.WIDTH(2*DW), .DEPTH(VQ_DEPTH)) u_vary (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (1'b0),
    .push_i  (vary_push_i),
    .wdata_i ({vary_c_i, vary_v_i}),
    .pop_i   (v_pop),
    .rdata_o (v_head),
    .empty_o (v_empty),
    .count_o (v_cnt)
  );

  ssp_wpair #(.DW(DW)) u_w (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flip_i  (pix_start_i),
    .wr_i    (w_we_i),
    .wdata_i (w_data_i),
    .cur_o   (w_cur),
    .nxt_o   (w_nxt)
  );

  assign vary_ready_o = (v_cnt != VCW'(VQ_DEPTH));
  assign acc5_we_o    = v_pop;
  assign acc5_data_o  = v_head[2*DW-1:DW];

  always_comb begin
    rd_data_a_o = '0;
    if (rd_en_a_i) begin
      case (rd_addr_a_i)
        RAW'(ADDR_UNIF):  rd_data_a_o = u_data;
        RAW'(ADDR_W_CUR): rd_data_a_o = w_cur;
        RAW'(ADDR_W_NXT): rd_data_a_o = w_nxt;
        default:          rd_data_a_o = '0;
      endcase
    end
    rd_data_b_o = '0;
    if (rd_en_b_i) begin
      case (rd_addr_b_i)
        RAW'(ADDR_UNIF): rd_data_b_o = u_data;
        RAW'(ADDR_VARY): rd_data_b_o = v_head[DW-1:0];
        default:         rd_data_b_o = '0;
      endcase
    end
  end

  assign left_after = left_q - CNTW'(v_pop && (left_q != '0));
  assign err_d = fire && ((s_rd && (prog_end_i || tail_q != '0)) ||
                          (prog_end_i && left_after != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q  <= err_d;
      left_q <= pix_start_i ? cfg_vary_cnt_i : left_after;
      if (fire && prog_end_i)          tail_q <= 2'(TAIL_SLOTS);
      else if (fire && tail_q != '0)   tail_q <= tail_q - 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int RAW      = 6,
  parameter int UQ_DEPTH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           issue_i,
  input logic           stall_o,
  input logic           ubase_we_i,
  input logic [AW-1:0]  ubase_i,
  input logic           rd_en_b_i,
  input logic [RAW-1:0] rd_addr_b_i,
  input logic           mreq_valid_o,
  input logic           mreq_ready_i,
  input logic [AW-1:0]  mreq_addr_o,
  input logic           mrsp_valid_i,
  input logic           acc5_we_o,
  input logic           err_o
);
  logic [7:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else out_q <= out_q + 8'(mreq_valid_o && mreq_ready_i) - 8'(mrsp_valid_i);
  end

  // R9
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= 8'(UQ_DEPTH));

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && !mreq_ready_i) |=>
      ((mreq_valid_o && $stable(mreq_addr_o)) || (issue_i && ubase_we_i)));

  // R2
  rewind_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !stall_o && ubase_we_i) |=>
      (!mreq_valid_o || mreq_addr_o == $past(ubase_i)));

  // R4
  acc5_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc5_we_o |-> (issue_i && !stall_o && rd_en_b_i && rd_addr_b_i == RAW'(6'd35)));

  // R6
  stall_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !acc5_we_o);

  // R7
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(issue_i && !stall_o));
endmodule

bind shd_stream_port ssp_chk #(.DW(DW), .AW(AW), .RAW(RAW), .UQ_DEPTH(UQ_DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_i      (issue_i),
  .stall_o      (stall_o),
  .ubase_we_i   (ubase_we_i),
  .ubase_i      (ubase_i),
  .rd_en_b_i    (rd_en_b_i),
  .rd_addr_b_i  (rd_addr_b_i),
  .mreq_valid_o (mreq_valid_o),
  .mreq_ready_i (mreq_ready_i),
  .mreq_addr_o  (mreq_addr_o),
  .mrsp_valid_i (mrsp_valid_i),
  .acc5_we_o    (acc5_we_o),
  .err_o        (err_o)
);

// File: tb/sim_shd_stream_port.sv
`timescale 1ns/1ps
module sim_shd_stream_port;
  localparam int VQ = 4;

  logic        clk, rst_n;
  logic [5:0]  cfg_cnt;
  logic        issue, pe, ena, enb, bwe, pix, wwe, vpush;
  logic [5:0]  aa, ab;
  logic [31:0] base, wdat, vv_d, vc_d;
  logic        vready, mreq_valid, mreq_ready, mrsp_valid;
  logic [31:0] mreq_addr, mrsp_data;
  logic        stall, acc5_we, err;
  logic [31:0] rda, rdb, acc5_data;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_uptr, w_cur_e, w_nxt_e;
  int v_pushed = 0, v_read = 0, b_left = 0, b_tail = 0;
  logic [31:0] pend[$];

  shd_stream_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_vary_cnt_i(cfg_cnt), .issue_i(issue),
    .prog_end_i(pe), .rd_en_a_i(ena), .rd_addr_a_i(aa), .rd_en_b_i(enb),
    .rd_addr_b_i(ab), .ubase_we_i(bwe), .ubase_i(base), .pix_start_i(pix),
    .w_we_i(wwe), .w_data_i(wdat), .vary_push_i(vpush), .vary_v_i(vv_d),
    .vary_c_i(vc_d), .vary_ready_o(vready), .mreq_valid_o(mreq_valid),
    .mreq_ready_i(mreq_ready), .mreq_addr_o(mreq_addr), .mrsp_valid_i(mrsp_valid),
    .mrsp_data_i(mrsp_data), .stall_o(stall), .rd_data_a_o(rda), .rd_data_b_o(rdb),
    .acc5_we_o(acc5_we), .acc5_data_o(acc5_data), .err_o(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] uval(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction
  function automatic logic [31:0] vval(input int k);
    return 32'(k) * 32'h01000193 + 32'h11;
  endfunction
  function automatic logic [31:0] cval(input int k);
    return ~vval(k) ^ 32'h0000FFFF;
  endfunction

  // memory model: in-order, random ready and latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mreq_ready <= 1'b0;
      mrsp_valid <= 1'b0;
      mrsp_data  <= '0;
      pend.delete();
    end else begin
      if (mreq_valid && mreq_ready) pend.push_back(mreq_addr);
      mreq_ready <= ($urandom % 4) != 0;
      if (pend.size() > 0 && ($urandom % 3) != 0) begin
        mrsp_valid <= 1'b1;
        mrsp_data  <= uval(pend.pop_front());
      end else begin
        mrsp_valid <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_vary();
    vpush = 1'b1;
    vv_d  = vval(v_pushed);
    vc_d  = cval(v_pushed);
    #1;
    chk(vready, "R3 queue room", {31'b0, vready}, 32'd1);
    step();
    vpush = 1'b0;
    v_pushed++;
  endtask

  task automatic pixel();
    pix = 1'b1;
    step();
    pix = 1'b0;
    b_left = int'(cfg_cnt);
    begin
      logic [31:0] t;
      t = w_cur_e; w_cur_e = w_nxt_e; w_nxt_e = t;
    end
  endtask

  task automatic wwrite(input logic [31:0] d);
    wwe = 1'b1; wdat = d;
    step();
    wwe = 1'b0;
    w_nxt_e = d;
  endtask

  task automatic instr(input logic ea, input logic [5:0] xa, input logic eb,
                       input logic [5:0] xb, input logic p, input logic bw,
                       input logic [31:0] bs);
    logic u_r, v_r, s_r, e_err;
    logic [31:0] ea_v, eb_v;
    issue = 1'b1; ena = ea; aa = xa; enb = eb; ab = xb; pe = p; bwe = bw; base = bs;
    #1;
    while (stall) begin
      step();
      #1;
    end
    u_r = (ea && xa == 6'd32) || (eb && xb == 6'd32);
    v_r = eb && xb == 6'd35;
    s_r = u_r || v_r;
    ea_v = !ea ? 32'd0 : (xa == 6'd32) ? uval(exp_uptr) : (xa == 6'd15) ? w_cur_e :
           (xa == 6'd14) ? w_nxt_e : 32'd0;
    eb_v = !eb ? 32'd0 : (xb == 6'd32) ? uval(exp_uptr) : (xb == 6'd35) ? vval(v_read) : 32'd0;
    chk(rda == ea_v, "R1/R5 port A data", rda, ea_v);
    chk(rdb == eb_v, "R1/R3 port B data", rdb, eb_v);
    chk(acc5_we == v_r, "R4 acc5 write enable", {31'b0, acc5_we}, {31'b0, v_r});
    if (v_r) chk(acc5_data == cval(v_read), "R4 acc5 coefficient", acc5_data, cval(v_read));
    if (v_r && b_left > 0) b_left--;
    e_err = (s_r && (p || b_tail > 0)) || (p && b_left != 0);
    step();
    issue = 1'b0; ena = 1'b0; enb = 1'b0; pe = 1'b0; bwe = 1'b0;
    #1;
    chk(err == e_err, "R7/R8 error pulse", {31'b0, err}, {31'b0, e_err});
    if (u_r) exp_uptr += 32'd4;
    if (v_r) v_read++;
    if (bw) exp_uptr = bs;
    if (p) b_tail = 2; else if (b_tail > 0) b_tail--;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED));
    rst_n = 1'b0; cfg_cnt = 6'd3;
    issue = 0; pe = 0; ena = 0; enb = 0; aa = 0; ab = 0; bwe = 0; base = 0;
    pix = 0; wwe = 0; wdat = 0; vpush = 0; vv_d = 0; vc_d = 0;
    exp_uptr = 0; w_cur_e = 0; w_nxt_e = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    chk(!stall, "R6 reset stall", {31'b0, stall}, 32'd0);
    chk(!err, "R7 reset err", {31'b0, err}, 32'd0);
    chk(!acc5_we, "R4 reset acc5", {31'b0, acc5_we}, 32'd0);
    chk(vready, "R3 reset ready", {31'b0, vready}, 32'd1);
    repeat (3) step();
    chk(!mreq_valid, "R9 no fetch before base", {31'b0, mreq_valid}, 32'd0);

    // R1: list order, dual-port single pop
    instr(0, 0, 0, 0, 0, 1, 32'h100);
    instr(1, 32, 0, 0, 0, 0, 0);
    instr(1, 32, 0, 0, 0, 0, 0);
    instr(0, 0, 1, 32, 0, 0, 0);
    instr(1, 32, 1, 32, 0, 0, 0);
    instr(1, 32, 0, 0, 0, 0, 0);

    // R2: rewind, same-instruction read sees old head
    instr(1, 32, 0, 0, 0, 1, 32'h400);
    instr(0, 0, 1, 32, 0, 0, 0);
    // R2/R6: just-flushed queue stalls the next read
    instr(0, 0, 0, 0, 0, 1, 32'h800);
    issue = 1'b1; ena = 1'b1; aa = 6'd32;
    #1;
    chk(stall, "R6 empty uniform stall", {31'b0, stall}, 32'd1);
    issue = 1'b0; ena = 1'b0;
    instr(1, 32, 0, 0, 0, 0, 0);

    // R3/R4: varyings and coefficients
    pixel();
    repeat (3) push_vary();
    instr(1, 35, 0, 0, 0, 0, 0);  // A35 pops nothing
    instr(0, 0, 1, 35, 0, 0, 0);
    instr(1, 15, 1, 35, 0, 0, 0);
    instr(0, 0, 1, 35, 0, 0, 0);

    // R6: varying read against empty queue
    issue = 1'b1; enb = 1'b1; ab = 6'd35;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(stall, "R6 empty varying stall", {31'b0, stall}, 32'd1);
      chk(!acc5_we, "R6 no acc5 during stall", {31'b0, acc5_we}, 32'd0);
      step();
    end
    issue = 1'b0; enb = 1'b0;
    push_vary();
    instr(0, 0, 1, 35, 0, 0, 0);

    // R5: W pair
    wwrite(32'h3F80_0001);
    pixel();
    instr(1, 15, 0, 0, 0, 0, 0);
    wwrite(32'h4000_0002);
    instr(1, 15, 0, 0, 0, 0, 0);  // unchanged before flip
    instr(1, 14, 0, 0, 0, 0, 0);
    pixel();
    instr(1, 15, 0, 0, 0, 0, 0);

    // R7/R8: clean program end
    pixel();
    repeat (3) push_vary();
    repeat (3) instr(0, 0, 1, 35, 0, 0, 0);
    instr(1, 15, 0, 0, 1, 0, 0);
    instr(1, 15, 0, 0, 0, 0, 0);
    instr(0, 0, 0, 0, 0, 0, 0);
    // R8: one varying left unread
    pixel();
    repeat (3) push_vary();
    repeat (2) instr(0, 0, 1, 35, 0, 0, 0);
    instr(0, 0, 0, 0, 1, 0, 0);
    instr(0, 0, 0, 0, 0, 0, 0);
    instr(0, 0, 0, 0, 0, 0, 0);
    // R8: last read inside program end counts; R7 read there is still an error
    pixel();
    repeat (2) push_vary();
    repeat (2) instr(0, 0, 1, 35, 0, 0, 0);
    instr(0, 0, 1, 35, 1, 0, 0);
    // R7: uniform read in first and second delay slot
    instr(1, 32, 0, 0, 0, 0, 0);
    instr(0, 0, 1, 32, 0, 0, 0);
    instr(1, 32, 0, 0, 0, 0, 0);  // outside tail: no error

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic ea_r, eb_r, bw_r;
      logic [5:0] xa_r, xb_r;
      logic [31:0] bs_r;
      ea_r = $urandom % 2;
      eb_r = $urandom % 2;
      case ($urandom % 4)
        0: xa_r = 6'd32; 1: xa_r = 6'd15; 2: xa_r = 6'd14; default: xa_r = 6'd3;
      endcase
      case ($urandom % 3)
        0: xb_r = 6'd32; 1: xb_r = 6'd35; default: xb_r = 6'd7;
      endcase
      bw_r = ($urandom % 16) == 0;
      bs_r = ($urandom % 4096) & 32'hFFC;
      if ((v_pushed - v_read) < VQ && ($urandom % 3) == 0) push_vary();
      if (eb_r && xb_r == 6'd35 && v_pushed == v_read) push_vary();
      if (($urandom % 32) == 0) wwrite($urandom);
      instr(ea_r, xa_r, eb_r, xb_r, 0, bw_r, bs_r);
    end

    finish_run();
  end
endmodule